// File: doc/BRIEF.md
# Way-Predicted Two-Cycle Instruction Cache

This block is a set-associative instruction cache for a processor fetch stage. Each set remembers which of its ways served it last. On a new fetch, the block indexes the set and reads only that remembered way. In the following cycle it compares the stored tag with the fetch tag. When the guess is right, the instruction word is returned in the second cycle, and the next fetch can be accepted in that same cycle. Fetches that hit the predicted way therefore stream at one per clock.

When the guess is wrong, the block stalls fetch and reads the other ways of the set, one per cycle. If one of them holds the line, the word is returned and the set's prediction is moved to that way. If no way matches, a whole line is requested from a simple memory port. When the line arrives, the requested word is returned in the same cycle, and the data, tag, valid bit and prediction of the chosen victim way are written.

Three event counters record predicted-way hits, hits in another way and refills, so the cache's behaviour can be observed from outside.

Top module: `icwp_cache`

## Requirements
- R1: A fetch accepted at a clock edge that hits the predicted way raises `rsp_valid` with the word during the very next cycle, with `fetch_stall` low. A fetch presented in that cycle is accepted at the following edge, so consecutive predicted hits stream at one per cycle.
- R2: Fetch addresses are word aligned, so bits [1:0] are zero. Bits [3:2] select the word, bits [9:4] select the set and bits [31:10] form the tag. Word k of a line occupies bits [32k+31:32k] of the line bus.
- R3: If the predicted way misses but another way holds the line, `fetch_stall` is high in the compare cycle. The word is returned one cycle later, which is the second cycle after acceptance with two ways.
- R4: After a hit found outside the predicted way, the set's prediction names that way, so the next fetch of the same line hits in the predicted way.
- R5: If no way matches, `mem_req_valid` rises with the line-aligned address (bits [3:0] zero). Both are held until `mem_rsp_valid`, and in that cycle `rsp_valid` carries the requested word taken from `mem_rsp_line`. With two ways, the request appears in the third cycle after acceptance.
- R6: A refill writes tag, data and valid into the victim way and points the prediction at it, so the next fetch of that line hits in the predicted way.
- R7: Reset clears every valid bit and zeroes the counters. The first fetch to any set after reset misses.
- R8: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way after the predicted one, modulo the number of ways.
- R9: `cnt_hit` increments once per predicted-way hit, `cnt_mispredict` once per hit found in another way, and `cnt_miss` once per completed refill.
- R10: While `fetch_stall` is high, `req_valid` and `req_addr` are ignored. A fetch held during a miss is not taken, and once the refill response has been returned no further response or memory request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 32 | Fetch byte address, word aligned |
| fetch_stall | output | 1 | High when a presented fetch cannot be taken |
| rsp_valid | output | 1 | Instruction word valid this cycle |
| rsp_data | output | 32 | Instruction word |
| mem_req_valid | output | 1 | Line refill request |
| mem_req_addr | output | 32 | Line-aligned refill address |
| mem_rsp_valid | input | 1 | Refill line present this cycle |
| mem_rsp_line | input | 128 | Refill line, word k in bits [32k+31:32k] |
| cnt_hit | output | 16 | Predicted-way hit count |
| cnt_mispredict | output | 16 | Other-way hit count |
| cnt_miss | output | 16 | Refill count |

## Verification
Two things can fall in one cycle: the tag compare and response for one fetch, and the set indexing and predicted-way read for the next fetch. This overlap happens when the first fetch hits its predicted way. The bench provokes it by presenting lines back to back, each in a different set and already resident. In each response cycle it checks the returned word against the earlier address, checks that stall is low, and checks that the next address was taken. It also drives a held request through a full miss. There it confirms that the refill response and the acceptance of a new fetch never share a cycle.

// File: rtl/icwp_pkg.sv
package icwp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOOK  = 2'd1,
      ST_PROBE = 2'd2,
      ST_MISS  = 2'd3
   } icwp_state_e;
endpackage

// File: rtl/icwp_ctr.sv
module icwp_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (inc) q <= q + 1'b1;
   end

   // R9: one step per event, none otherwise
   p_ctr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> q == CNT_W'($past(q) + 1'b1));
   p_ctr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(q));
endmodule

// File: rtl/icwp_tag_store.sv
module icwp_tag_store #(
   parameter int WAYS  = 2,
   parameter int SETS  = 64,
   parameter int TAG_W = 22,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   // registered single-way read
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_set,
   input  logic [WAY_W-1:0] rd_way,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_vld,
   // combinational prediction / valid row lookup
   input  logic [IDX_W-1:0] lk_set,
   output logic [WAY_W-1:0] lk_pred,
   output logic [WAYS-1:0]  lk_vld,
   // refill write
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [TAG_W-1:0] wr_tag,
   // prediction update
   input  logic             pupd_en,
   input  logic [IDX_W-1:0] pupd_set,
   input  logic [WAY_W-1:0] pupd_way
);
   logic [TAG_W-1:0] tag_q  [SETS][WAYS];
   logic [WAYS-1:0]  vld_q  [SETS];
   logic [WAY_W-1:0] pred_q [SETS];

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]  <= '0;
            pred_q[s] <= '0;
         end
      end else begin
         if (wr_en)   vld_q[wr_set][wr_way] <= 1'b1;
         if (pupd_en) pred_q[pupd_set]      <= pupd_way;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld <= 1'b0;
         rd_tag <= '0;
      end else if (rd_en) begin
         rd_vld <= vld_q[rd_set][rd_way];
         rd_tag <= tag_q[rd_set][rd_way];
      end
   end

   assign lk_pred = pred_q[lk_set];
   assign lk_vld  = vld_q[lk_set];

   // R6: a refilled way reads back valid
   p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_set)][$past(wr_way)]);
   // R4: prediction follows the last update
   p_pred_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pupd_en |=> pred_q[$past(pupd_set)] == $past(pupd_way));
endmodule

// File: rtl/icwp_data_store.sv
module icwp_data_store #(
   parameter int WAYS   = 2,
   parameter int SETS   = 64,
   parameter int LINE_W = 128,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_set,
   input  logic [WAY_W-1:0]  rd_way,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_set,
   input  logic [WAY_W-1:0]  wr_way,
   input  logic [LINE_W-1:0] wr_line
);
   logic [LINE_W-1:0] way_rd [WAYS];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [LINE_W-1:0] mem_q [SETS];
      always_ff @(posedge clk) begin
         if (wr_en && wr_way == WAY_W'(w)) mem_q[wr_set] <= wr_line;
      end
      assign way_rd[w] = mem_q[rd_set];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_line <= '0;
      else if (rd_en) rd_line <= way_rd[rd_way];
   end
endmodule

// File: rtl/icwp_cache.sv
module icwp_cache
   import icwp_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 32,
   parameter int LINE_BYTES  = 16,
   parameter int WAYS        = 2,
   parameter int SETS        = 64,
   parameter int CNT_W       = 16,
   parameter int VICTIM_MODE = 0,
   localparam int LINE_W     = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              fetch_stall,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_data,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [LINE_W-1:0] mem_rsp_line,
   output logic [CNT_W-1:0]  cnt_hit,
   output logic [CNT_W-1:0]  cnt_mispredict,
   output logic [CNT_W-1:0]  cnt_miss
);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int WPL        = LINE_BYTES / WORD_BYTES;
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int BSEL_W     = $clog2(WORD_BYTES);
   localparam int WSEL_W     = $clog2(WPL);
   localparam int IDX_W      = $clog2(SETS);
   localparam int WAY_W      = $clog2(WAYS);
   localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
   localparam int WA_W       = ADDR_W - BSEL_W;
   localparam logic [WAY_W-1:0] LAST_TRY = WAY_W'(WAYS - 1);

   initial begin
      assert (WAYS >= 2 && (1 << WAY_W) == WAYS) else $error("WAYS must be a power of two >= 2");
      assert ((1 << IDX_W) == SETS) else $error("SETS must be a power of two");
      assert (WORD_W % 8 == 0 && (1 << BSEL_W) == WORD_BYTES) else $error("bad WORD_W");
      assert (WPL >= 2 && (1 << WSEL_W) == WPL) else $error("line must hold 2^n >= 2 words");
      assert (TAG_W >= 1) else $error("address too narrow");
   end

   icwp_state_e state_q, state_d;
   logic [WA_W-1:0]  q_waddr;
   logic [WAY_W-1:0] q_way, tried_q;

   logic [IDX_W-1:0]  q_set, req_set, lk_set, rd_set;
   logic [TAG_W-1:0]  q_tag, rd_tag;
   logic [WSEL_W-1:0] q_wsel;
   logic [WAY_W-1:0]  rd_way, lk_pred, victim, next_way;
   logic [WAYS-1:0]   lk_vld;
   logic [LINE_W-1:0] rd_line;
   logic              rd_vld, rd_en;
   logic              probe_hit, in_cmp, look_hit, probe_last, accept, fill, pupd_en;
   logic [WAY_W-1:0]  pupd_way;
   logic              ev_hit, ev_mp, ev_miss;

   assign q_set   = q_waddr[OFF_W-BSEL_W +: IDX_W];
   assign q_tag   = q_waddr[WA_W-1 -: TAG_W];
   assign q_wsel  = q_waddr[WSEL_W-1:0];
   assign req_set = req_addr[OFF_W +: IDX_W];
   assign lk_set  = (state_q == ST_MISS) ? q_set : req_set;

   // compare stage
   assign probe_hit  = rd_vld && (rd_tag == q_tag);
   assign in_cmp     = (state_q == ST_LOOK) || (state_q == ST_PROBE);
   assign look_hit   = (state_q == ST_LOOK) && probe_hit;
   assign probe_last = (state_q == ST_PROBE) && (tried_q == LAST_TRY);
   assign accept     = req_valid && ((state_q == ST_IDLE) || look_hit);
   assign fill       = (state_q == ST_MISS) && mem_rsp_valid;
   assign next_way   = q_way + 1'b1;

   assign fetch_stall = ((state_q == ST_LOOK) && !probe_hit) ||
                        (state_q == ST_PROBE) || (state_q == ST_MISS);

   // array read: predicted way on accept, next alternate way on a wrong guess
   assign rd_en  = accept || (in_cmp && !probe_hit && !probe_last);
   assign rd_set = accept ? req_set : q_set;
   assign rd_way = accept ? lk_pred : next_way;

   // victim choice
   if (VICTIM_MODE == 0) begin : g_vic_inv
      always_comb begin
         victim = lk_pred + 1'b1;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (!lk_vld[w]) victim = WAY_W'(w);
         end
      end
   end else begin : g_vic_rot
      assign victim = lk_pred + 1'b1;
   end

   assign pupd_en  = fill || ((state_q == ST_PROBE) && probe_hit);
   assign pupd_way = fill ? victim : q_way;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_LOOK;
         ST_LOOK:  if (probe_hit) state_d = accept ? ST_LOOK : ST_IDLE;
                   else           state_d = ST_PROBE;
         ST_PROBE: if (probe_hit)       state_d = ST_IDLE;
                   else if (probe_last) state_d = ST_MISS;
         ST_MISS:  if (mem_rsp_valid) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         q_waddr <= '0;
         q_way   <= '0;
         tried_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) q_waddr <= req_addr[ADDR_W-1:BSEL_W];
         if (rd_en)  q_way   <= rd_way;
         if (accept)     tried_q <= '0;
         else if (rd_en) tried_q <= tried_q + 1'b1;
      end
   end

   icwp_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk, .rst_n,
      .rd_en, .rd_set, .rd_way, .rd_tag, .rd_vld,
      .lk_set, .lk_pred, .lk_vld,
      .wr_en(fill), .wr_set(q_set), .wr_way(victim), .wr_tag(q_tag),
      .pupd_en, .pupd_set(q_set), .pupd_way
   );

   icwp_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)) u_data (
      .clk, .rst_n,
      .rd_en, .rd_set, .rd_way, .rd_line,
      .wr_en(fill), .wr_set(q_set), .wr_way(victim), .wr_line(mem_rsp_line)
   );

   // word select
   logic [WORD_W-1:0] arr_words [WPL];
   logic [WORD_W-1:0] mem_words [WPL];
   for (genvar k = 0; k < WPL; k++) begin : g_word
      assign arr_words[k] = rd_line[k*WORD_W +: WORD_W];
      assign mem_words[k] = mem_rsp_line[k*WORD_W +: WORD_W];
   end

   assign rsp_valid     = (in_cmp && probe_hit) || fill;
   assign rsp_data      = fill ? mem_words[q_wsel] : arr_words[q_wsel];
   assign mem_req_valid = (state_q == ST_MISS);
   assign mem_req_addr  = {q_waddr[WA_W-1:OFF_W-BSEL_W], OFF_W'(0)};

   assign ev_hit  = look_hit;
   assign ev_mp   = (state_q == ST_PROBE) && probe_hit;
   assign ev_miss = fill;

   icwp_ctr #(.CNT_W(CNT_W)) u_cnt_hit  (.clk, .rst_n, .inc(ev_hit),  .q(cnt_hit));
   icwp_ctr #(.CNT_W(CNT_W)) u_cnt_mp   (.clk, .rst_n, .inc(ev_mp),   .q(cnt_mispredict));
   icwp_ctr #(.CNT_W(CNT_W)) u_cnt_miss (.clk, .rst_n, .inc(ev_miss), .q(cnt_miss));

   // R2: fetch addresses word aligned, refill addresses line aligned
   p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_addr[BSEL_W-1:0] == '0);
   p_line_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[OFF_W-1:0] == '0);
   // R5: refill request held steady until answered
   p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));
   // R9: at most one counted event per cycle
   p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_hit, ev_mp, ev_miss}));
   // R1: a response only ever follows an accepted fetch
   p_rsp_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> state_q != ST_IDLE);
   // R10: refill response never coincides with taking a new fetch
   p_miss_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fill |=> state_q == ST_IDLE);
endmodule

// File: tb/tb_icwp_cache.sv
module tb_icwp_cache;
   localparam int SETS = 64;
   localparam int WAYS = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic         fetch_stall, rsp_valid, mem_req_valid;
   logic [31:0]  rsp_data, mem_req_addr;
   logic         mem_rsp_valid = 1'b0;
   logic [127:0] mem_rsp_line = '0;
   logic [15:0]  cnt_hit, cnt_mispredict, cnt_miss;

   icwp_cache dut (
      .clk, .rst_n, .req_valid, .req_addr, .fetch_stall, .rsp_valid, .rsp_data,
      .mem_req_valid, .mem_req_addr, .mem_rsp_valid, .mem_rsp_line,
      .cnt_hit, .cnt_mispredict, .cnt_miss
   );

   always #2 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int last_d = 0;

   // reference model state
   bit m_vld [SETS][WAYS];
   int m_tag [SETS][WAYS];
   int m_pred [SETS];
   int e_hit = 0, e_mp = 0, e_miss = 0;

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(input logic [31:0] a);
      logic [31:0] ln;
      logic [31:0] k;
      ln = a >> 4;
      k  = (a >> 2) & 32'h3;
      return (ln * 32'h9E37_79B1) ^ ((k + 1) * 32'h0100_0193) ^ 32'hA5A5_0000;
   endfunction

   function automatic logic [127:0] line_of(input logic [31:0] la);
      logic [127:0] l;
      for (int k = 0; k < 4; k++) l[k*32 +: 32] = word_of({la[31:4], 2'(k), 2'b00});
      return l;
   endfunction

   function automatic logic [31:0] mk(input int tag, input int set, input int wd);
      return {22'(tag), 6'(set), 2'(wd), 2'b00};
   endfunction

   // 0 = predicted hit, 1 = other-way hit, 2 = miss
   function automatic int model_access(input logic [31:0] a);
      int s, t, p, v;
      s = int'(a[9:4]);
      t = int'(a[31:10]);
      p = m_pred[s];
      if (m_vld[s][p] && m_tag[s][p] == t) begin e_hit++; return 0; end
      for (int w = 0; w < WAYS; w++) begin
         if (w != p && m_vld[s][w] && m_tag[s][w] == t) begin
            m_pred[s] = w; e_mp++; return 1;
         end
      end
      v = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[s][w]) v = w;
      if (v < 0) v = (p + 1) % WAYS;
      m_vld[s][v] = 1'b1; m_tag[s][v] = t; m_pred[s] = v; e_miss++;
      return 2;
   endfunction

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (mem_req_valid) begin
            last_d = int'($urandom % 4);
            repeat (last_d) @(negedge clk);
            mem_rsp_line  = line_of(mem_req_addr);
            mem_rsp_valid = 1'b1;
         end
      end
   end

   task automatic check_counters(input string tag);
      chk(cnt_hit == 16'(e_hit), {tag, " R9 hit count"}, 64'(cnt_hit), 64'(e_hit));
      chk(cnt_mispredict == 16'(e_mp), {tag, " R9 mispredict count"}, 64'(cnt_mispredict), 64'(e_mp));
      chk(cnt_miss == 16'(e_miss), {tag, " R9 miss count"}, 64'(cnt_miss), 64'(e_miss));
   endtask

   task automatic do_fetch(input logic [31:0] a, input bit hold);
      int cls, lat, guard, exp_lat;
      bit saw_mem;
      cls = model_access(a);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      #1;
      guard = 0;
      while (fetch_stall && guard < 50) begin @(negedge clk); #1; guard++; end
      @(negedge clk);
      if (hold) req_addr = a ^ 32'h00F0_0000;
      else      req_valid = 1'b0;
      #1;
      lat = 1; saw_mem = 1'b0;
      while (lat < 60) begin
         if (mem_req_valid && !saw_mem) begin
            saw_mem = 1'b1;
            chk(mem_req_addr == {a[31:4], 4'b0}, "R5 refill address", 64'(mem_req_addr), 64'({a[31:4], 4'b0}));
         end
         if (rsp_valid) break;
         @(negedge clk); #1; lat++;
      end
      chk(rsp_valid && rsp_data == word_of(a), "R2 returned word", 64'(rsp_data), 64'(word_of(a)));
      exp_lat = (cls == 0) ? 1 : (cls == 1) ? 2 : 3 + last_d;
      chk(lat == exp_lat, (cls == 0) ? "R1 hit latency" : (cls == 1) ? "R3 other-way latency" : "R5 miss latency",
          64'(lat), 64'(exp_lat));
      chk(fetch_stall == (cls != 0), (cls == 0) ? "R1 no stall on hit" : "R3 stall while searching",
          64'(fetch_stall), 64'(cls != 0));
      chk(saw_mem == (cls == 2), "R5 refill requested only on miss", 64'(saw_mem), 64'(cls == 2));
      if (hold) req_valid = 1'b0;
      @(negedge clk); #1;
      check_counters("fetch");
      if (hold) begin
         chk(!rsp_valid && !mem_req_valid, "R10 held fetch ignored", 64'({rsp_valid, mem_req_valid}), 64'(0));
         @(negedge clk); #1;
         chk(!rsp_valid && !mem_req_valid, "R10 still quiet", 64'({rsp_valid, mem_req_valid}), 64'(0));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int mb;
      logic [31:0] a0, b0, c0;
      void'($urandom(32'd12345));
      for (int s = 0; s < SETS; s++) begin
         m_pred[s] = 0;
         for (int w = 0; w < WAYS; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = 0; end
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R7 reset state
      chk(!fetch_stall && !rsp_valid && !mem_req_valid, "R7 idle after reset",
          64'({fetch_stall, rsp_valid, mem_req_valid}), 64'(0));
      check_counters("R7 reset");

      // R7 cold access misses (checked through latency/refill inside do_fetch)
      do_fetch(mk(7, 3, 1), 1'b0);
      chk(cnt_miss == 16'd1, "R7 first access misses", 64'(cnt_miss), 64'(1));
      // R6 refilled line now hits predicted way
      do_fetch(mk(7, 3, 2), 1'b0);
      chk(cnt_hit == 16'd1, "R6 hit after refill", 64'(cnt_hit), 64'(1));

      // R8 victim and R4 prediction update in set 5
      do_fetch(mk(1, 5, 0), 1'b0);
      do_fetch(mk(2, 5, 1), 1'b0);
      do_fetch(mk(1, 5, 2), 1'b0);   // other-way hit, pred -> way 0
      do_fetch(mk(1, 5, 3), 1'b0);   // R4 now a predicted hit
      do_fetch(mk(3, 5, 0), 1'b0);   // set full: victim is way 1, evicts tag 2
      mb = int'(cnt_miss);
      do_fetch(mk(2, 5, 0), 1'b0);
      chk(int'(cnt_miss) == mb + 1, "R8 evicted line misses again", 64'(cnt_miss), 64'(mb + 1));

      // R10 held request during a miss
      do_fetch(mk(9, 22, 3), 1'b1);

      // R1 back-to-back predicted hits
      a0 = mk(11, 40, 0); b0 = mk(12, 41, 1); c0 = mk(13, 42, 3);
      do_fetch(a0, 1'b0); do_fetch(b0, 1'b0); do_fetch(c0, 1'b0);
      void'(model_access(a0)); void'(model_access(b0)); void'(model_access(c0));
      @(negedge clk); req_valid = 1'b1; req_addr = a0;
      @(negedge clk); req_addr = b0; #1;
      chk(rsp_valid && !fetch_stall && rsp_data == word_of(a0), "R1 stream word 0", 64'(rsp_data), 64'(word_of(a0)));
      @(negedge clk); req_addr = c0; #1;
      chk(rsp_valid && !fetch_stall && rsp_data == word_of(b0), "R1 stream word 1", 64'(rsp_data), 64'(word_of(b0)));
      @(negedge clk); req_valid = 1'b0; #1;
      chk(rsp_valid && rsp_data == word_of(c0), "R1 stream word 2", 64'(rsp_data), 64'(word_of(c0)));
      @(negedge clk); #1;
      chk(!rsp_valid, "R1 stream ends", 64'(rsp_valid), 64'(0));
      check_counters("R1 stream");

      // random mix over a small pool to force hits, other-way hits and misses
      for (int i = 0; i < 300; i++) begin
         int tg, st;
         case ($urandom % 4)
            0: st = 0; 1: st = 1; 2: st = 17; default: st = 63;
         endcase
         case ($urandom % 4)
            0: tg = 1; 1: tg = 2; 2: tg = 3; default: tg = 22'h3F_FFFF;
         endcase
         do_fetch(mk(tg, st, int'($urandom % 4)), 1'b0);
         repeat ($urandom % 3) @(negedge clk);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule